// File: doc/BRIEF.md
# Backup and Reset Mode Sequencer

This block runs on the always-on real-time clock and decides, from an oscillator enable and an active-low external reset, whether the chip is in normal operation, in a runtime reset, in low-power backup, or waking up from backup. From that decision it produces a qualified internal reset, a run enable for the main oscillator and PLL, a retention flag for the battery-backed SRAM region, and a safe-state control for each external pin group. It also opens the gate of the once-per-second pulse output one second after the internal reset is released.

The chip enters backup only when the oscillator enable and the external reset are both low. To wake, the oscillator enable must rise first. The internal reset then stays asserted until a stabilization count of at least 100 ms has elapsed, the external reset is high, and the PLL reports lock. A reset pulse shorter than 100 us during normal operation is filtered out. All three inputs are synchronized with two flops on the real-time clock before any decision uses them.

Top module: `bkp_seq`

## Requirements
- R1: Each input passes through two synchronizer flops, so an input change first affects `state_o` on the third rising clock edge after it.
- R2: While `por_n_i` is low, the block is in backup. The state codes are 0 = normal, 1 = runtime reset, 2 = backup and 3 = waking.
- R3: When the synchronized oscillator enable and external reset are both low, the next state is backup (code 2) from any state. In backup `retain_o` is 1 and `osc_run_o` is 0.
- R4: Backup is left only when the synchronized oscillator enable is high, and the exit goes to waking (code 3) with `osc_run_o` set to 1. The external reset alone does not end backup.
- R5: Waking moves to normal only on an edge where all three hold: the stabilization counter has already reached WAKE_CYC = ceil(TICK_HZ*WAKE_MS/1000), the synchronized external reset is high, and the synchronized PLL lock is high. If the external reset is released early, `core_rst_n_o` stays at 0.
- R6: In normal, the external reset must be low for RST_MIN_CYC = ceil(TICK_HZ*RST_MIN_US/1e6) consecutive synchronized samples (4 at default) before the block enters runtime reset (code 1). A shorter low pulse leaves the state, `core_rst_n_o` and `pps_en_o` unchanged.
- R7: Runtime reset returns to normal once the synchronized external reset and the synchronized PLL lock are both high.
- R8: In every state except normal, `bus_pd_en_o`, `txd_hiz_o`, `strobe_hi_o` and `addr_lo_o` are all 1. In normal they are all 0.
- R9: `pps_en_o` rises exactly TICK_HZ clock edges after the block enters normal. It is 0 in every other state and restarts its count on each new entry to normal.
- R10: In waking, a low synchronized oscillator enable with the external reset high clears the stabilization count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc_i | input | 1 | Always-running real-time clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| osc_en_i | input | 1 | Oscillator enable from the board, asynchronous |
| ext_rst_n_i | input | 1 | External reset, active low, asynchronous |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| core_rst_n_o | output | 1 | Qualified internal reset, active low |
| osc_run_o | output | 1 | Run enable for the main oscillator and PLL |
| retain_o | output | 1 | Retention flag for the battery-backed SRAM |
| bus_pd_en_o | output | 1 | Pull-down enable for the data bus and general I/O ports |
| txd_hiz_o | output | 1 | Puts the serial transmit pin into high impedance |
| strobe_hi_o | output | 1 | Forces the chip-select, write and read strobes high |
| addr_lo_o | output | 1 | Forces the address bus and pulse output low |
| pps_en_o | output | 1 | Gate for the once-per-second pulse output |
| state_o | output | 2 | Encoded current state |

## Verification
An error in the sequencer state shows on `state_o` and on the decoded outputs on the edge where it occurs, so it is visible at once at the ports. A miscounting counter shows more slowly, because each one has its own window. A wrong runtime-reset filter shows within four cycles of a low pulse. A wrong stabilization counter shows as an early or late wake-up thousands of cycles later. A wrong pulse-gate counter shows only after about one second of simulated time. For this reason the bench runs each window to its end and compares every output on every clock.

// File: rtl/bkp_pkg.sv
package bkp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_RESET  = 2'd1,
        ST_BACKUP = 2'd2,
        ST_WAKE   = 2'd3
    } pwr_state_e;

    localparam int SYNC_STAGES = 2;

    localparam int IN_OSC  = 0;
    localparam int IN_RST  = 1;
    localparam int IN_LOCK = 2;
    localparam int IN_W    = 3;

endpackage

// File: rtl/bkp_sync.sv
module bkp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/bkp_fsm.sv
module bkp_fsm
    import bkp_pkg::*;
#(
    parameter int WAKE_CYC    = 3277,
    parameter int RST_MIN_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_s_i,
    input  logic       rst_s_i,
    input  logic       lock_s_i,
    output pwr_state_e state_o
);

    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam int RW = $clog2(RST_MIN_CYC + 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC);
    localparam logic [RW-1:0] RST_LAST  = RW'(RST_MIN_CYC - 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [WW-1:0] wake_cnt;
        logic [RW-1:0] low_cnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.wake_cnt = '0;
        r_d.low_cnt  = '0;
        if (!osc_s_i && !rst_s_i) begin
            r_d.st = ST_BACKUP;
        end else begin
            unique case (r_q.st)
                ST_NORMAL: begin
                    if (!rst_s_i) begin
                        if (r_q.low_cnt == RST_LAST) begin
                            r_d.st = ST_RESET;
                        end else begin
                            r_d.low_cnt = r_q.low_cnt + 1'b1;
                        end
                    end
                end
                ST_RESET: begin
                    if (rst_s_i && lock_s_i) begin
                        r_d.st = ST_NORMAL;
                    end
                end
                ST_BACKUP: begin
                    if (osc_s_i) begin
                        r_d.st = ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (r_q.wake_cnt == WAKE_LAST && rst_s_i && lock_s_i) begin
                        r_d.st = ST_NORMAL;
                    end else if (!osc_s_i) begin
                        r_d.wake_cnt = '0;
                    end else if (r_q.wake_cnt != WAKE_LAST) begin
                        r_d.wake_cnt = r_q.wake_cnt + 1'b1;
                    end else begin
                        r_d.wake_cnt = r_q.wake_cnt;
                    end
                end
                default: r_d.st = ST_BACKUP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_BACKUP;
            r_q.wake_cnt <= '0;
            r_q.low_cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

    assert_backup_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_s_i && !rst_s_i) |=> (r_q.st == ST_BACKUP));

    assert_backup_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BACKUP && osc_s_i) |=> (r_q.st == ST_WAKE));

    assert_wake_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAKE && r_q.wake_cnt != WAKE_LAST) |=> (r_q.st != ST_NORMAL));

    assert_glitch_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_NORMAL && rst_s_i) |=> (r_q.st != ST_RESET));

    assert_lock_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RESET && !lock_s_i) |=> (r_q.st != ST_NORMAL));

endmodule

// File: rtl/bkp_pin_safe.sv
module bkp_pin_safe
    import bkp_pkg::*;
(
    input  pwr_state_e state_i,
    output logic       bus_pd_en_o,
    output logic       txd_hiz_o,
    output logic       strobe_hi_o,
    output logic       addr_lo_o
);

    logic safe;

    always_comb begin
        safe        = (state_i != ST_NORMAL);
        bus_pd_en_o = safe;
        txd_hiz_o   = safe;
        strobe_hi_o = safe;
        addr_lo_o   = safe;
    end

endmodule

// File: rtl/bkp_pps_gate.sv
module bkp_pps_gate
    import bkp_pkg::*;
#(
    parameter int DELAY_CYC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state_i,
    output logic       pps_en_o
);

    localparam int PW = $clog2(DELAY_CYC + 1);
    localparam logic [PW-1:0] LAST = PW'(DELAY_CYC - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          en;
    } pps_regs_t;

    pps_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state_i != ST_NORMAL) begin
            r_d.cnt = '0;
            r_d.en  = 1'b0;
        end else if (r_q.cnt == LAST) begin
            r_d.en = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.en  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pps_en_o = r_q.en && (state_i == ST_NORMAL);

endmodule

// File: rtl/bkp_seq.sv
module bkp_seq
    import bkp_pkg::*;
#(
    parameter int TICK_HZ    = 32768,
    parameter int RST_MIN_US = 100,
    parameter int WAKE_MS    = 100
) (
    input  logic       clk_rtc_i,
    input  logic       por_n_i,
    input  logic       osc_en_i,
    input  logic       ext_rst_n_i,
    input  logic       pll_lock_i,
    output logic       core_rst_n_o,
    output logic       osc_run_o,
    output logic       retain_o,
    output logic       bus_pd_en_o,
    output logic       txd_hiz_o,
    output logic       strobe_hi_o,
    output logic       addr_lo_o,
    output logic       pps_en_o,
    output logic [1:0] state_o
);

    localparam int RST_MIN_CYC = (TICK_HZ * RST_MIN_US + 999_999) / 1_000_000;
    localparam int WAKE_CYC    = (TICK_HZ * WAKE_MS + 999) / 1000;
    localparam int PPS_CYC     = TICK_HZ;

    logic [IN_W-1:0] raw_in, sync_in;
    pwr_state_e      st;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_OSC]  = osc_en_i;
        raw_in[IN_RST]  = ext_rst_n_i;
        raw_in[IN_LOCK] = pll_lock_i;
    end

    bkp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_rtc_i),
        .rst_n (por_n_i),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    bkp_fsm #(.WAKE_CYC(WAKE_CYC), .RST_MIN_CYC(RST_MIN_CYC)) u_fsm (
        .clk      (clk_rtc_i),
        .rst_n    (por_n_i),
        .osc_s_i  (sync_in[IN_OSC]),
        .rst_s_i  (sync_in[IN_RST]),
        .lock_s_i (sync_in[IN_LOCK]),
        .state_o  (st)
    );

    bkp_pin_safe u_pins (
        .state_i     (st),
        .bus_pd_en_o (bus_pd_en_o),
        .txd_hiz_o   (txd_hiz_o),
        .strobe_hi_o (strobe_hi_o),
        .addr_lo_o   (addr_lo_o)
    );

    bkp_pps_gate #(.DELAY_CYC(PPS_CYC)) u_pps (
        .clk      (clk_rtc_i),
        .rst_n    (por_n_i),
        .state_i  (st),
        .pps_en_o (pps_en_o)
    );

    assign core_rst_n_o = (st == ST_NORMAL);
    assign osc_run_o    = (st != ST_BACKUP);
    assign retain_o     = (st == ST_BACKUP);
    assign state_o      = st;

    assert_pins_safe_R8: assert property (@(posedge clk_rtc_i) disable iff (!por_n_i)
        !core_rst_n_o |-> (bus_pd_en_o && txd_hiz_o && strobe_hi_o && addr_lo_o));

    assert_retain_osc_off_R3: assert property (@(posedge clk_rtc_i) disable iff (!por_n_i)
        retain_o |-> !osc_run_o);

    assert_pps_after_release_R9: assert property (@(posedge clk_rtc_i) disable iff (!por_n_i)
        pps_en_o |-> (core_rst_n_o && $past(core_rst_n_o)));

endmodule

// File: tb/tb_bkp_seq.sv
module tb_bkp_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TICK = 32768;
    localparam int WAKE = (TICK * 100 + 999) / 1000;
    localparam int RMIN = (TICK * 100 + 999_999) / 1_000_000;

    logic clk = 1'b0;
    logic por_n, osc_en, ext_rst_n, pll_lock;
    logic core_rst_n, osc_run, retain, bus_pd, txd_hiz, strobe_hi, addr_lo, pps_en;
    logic [1:0] state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference
    int m_st, m_wc, m_lc, m_pn;
    bit m_o1, m_o2, m_r1, m_r2, m_l1, m_l2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bkp_seq dut (
        .clk_rtc_i    (clk),
        .por_n_i      (por_n),
        .osc_en_i     (osc_en),
        .ext_rst_n_i  (ext_rst_n),
        .pll_lock_i   (pll_lock),
        .core_rst_n_o (core_rst_n),
        .osc_run_o    (osc_run),
        .retain_o     (retain),
        .bus_pd_en_o  (bus_pd),
        .txd_hiz_o    (txd_hiz),
        .strobe_hi_o  (strobe_hi),
        .addr_lo_o    (addr_lo),
        .pps_en_o     (pps_en),
        .state_o      (state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_st = 2; m_wc = 0; m_lc = 0; m_pn = 0;
            m_o1 = 0; m_o2 = 0; m_r1 = 0; m_r2 = 0; m_l1 = 0; m_l2 = 0;
        end else begin
            int nst;
            nst = m_st;
            if (!m_o2 && !m_r2) nst = 2;
            else begin
                case (m_st)
                    0: if (!m_r2 && m_lc == RMIN - 1) nst = 1;
                    1: if (m_r2 && m_l2) nst = 0;
                    2: if (m_o2) nst = 3;
                    default: if (m_wc == WAKE && m_r2 && m_l2) nst = 0;
                endcase
            end
            m_lc = (m_st == 0 && nst == 0 && !m_r2) ? m_lc + 1 : 0;
            if (m_st == 3 && nst == 3) m_wc = m_o2 ? ((m_wc < WAKE) ? m_wc + 1 : WAKE) : 0;
            else m_wc = 0;
            m_pn = (m_st == 0) ? m_pn + 1 : 0;
            m_st = nst;
            m_o2 = m_o1; m_o1 = osc_en;
            m_r2 = m_r1; m_r1 = ext_rst_n;
            m_l2 = m_l1; m_l1 = pll_lock;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (por_n && !done) begin
            int safe;
            safe = (m_st != 0) ? 15 : 0;
            chk("R1", "state", int'(state), m_st);
            chk("R5", "core_rst_n", int'(core_rst_n), int'(m_st == 0));
            chk("R4", "osc_run", int'(osc_run), int'(m_st != 2));
            chk("R3", "retain", int'(retain), int'(m_st == 2));
            chk("R8", "pins", int'({bus_pd, txd_hiz, strobe_hi, addr_lo}), safe);
            chk("R9", "pps_en", int'(pps_en), int'(m_st == 0 && m_pn >= TICK));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        por_n = 0; osc_en = 1; ext_rst_n = 0; pll_lock = 0;
        step(4);
        chk("R2", "state in por", int'(state), 2);
        chk("R2", "core_rst_n in por", int'(core_rst_n), 0);
        chk("R2", "retain in por", int'(retain), 1);
        por_n = 1;
        step(5);
        chk("R4", "waking after por", int'(state), 3);
        chk("R4", "osc_run waking", int'(osc_run), 1);
        step(100); ext_rst_n = 1;
        step(100); pll_lock = 1;
        step(1000);
        chk("R5", "early reset release held", int'(core_rst_n), 0);
        step(2500);
        chk("R5", "normal after wake", int'(state), 0);
        step(TICK + 5);
        chk("R9", "pps enabled", int'(pps_en), 1);
        // short pulse of RMIN-1 cycles
        ext_rst_n = 0; step(RMIN - 1); ext_rst_n = 1;
        step(10);
        chk("R6", "short pulse state", int'(state), 0);
        chk("R6", "short pulse core_rst_n", int'(core_rst_n), 1);
        chk("R6", "short pulse pps", int'(pps_en), 1);
        // long pulse with lock low
        pll_lock = 0; ext_rst_n = 0; step(RMIN); ext_rst_n = 1;
        step(6);
        chk("R6", "long pulse reset", int'(state), 1);
        chk("R9", "pps off in reset", int'(pps_en), 0);
        pll_lock = 1;
        step(6);
        chk("R7", "reset release", int'(state), 0);
        step(10);
        chk("R9", "pps restarts count", int'(pps_en), 0);
        // backup entry timing
        osc_en = 0; ext_rst_n = 0;
        step(2);
        chk("R1", "two edges no effect", int'(state), 0);
        step(1);
        chk("R3", "backup entered", int'(state), 2);
        chk("R3", "retain", int'(retain), 1);
        chk("R8", "pins safe", int'({bus_pd, txd_hiz, strobe_hi, addr_lo}), 15);
        ext_rst_n = 1;
        step(10);
        chk("R4", "reset alone keeps backup", int'(state), 2);
        osc_en = 1;
        step(1500);
        chk("R4", "waking", int'(state), 3);
        osc_en = 0; step(5); osc_en = 1;
        step(3000);
        chk("R10", "count cleared", int'(state), 3);
        step(500);
        chk("R10", "normal after restart", int'(state), 0);
        chk("R8", "pins released", int'({bus_pd, txd_hiz, strobe_hi, addr_lo}), 0);
        step(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule